// File: doc/BRIEF.md
# Infrared Pulse Run-Length Sampler

This block takes the single-bit output of an infrared receiver and turns it into a stream of run-length bytes. The input is synchronised, and it can be inverted for receivers whose idle level is high. It is then sampled on a tick made by dividing the base clock. A programmable filter accepts a change of level only once the new level has lasted long enough. Each run of equal filtered level becomes one byte. The byte carries the level and the number of sample periods the run lasted. A run too long for one byte is split into several bytes.

Capture of a packet begins only once a mark has lasted a programmable activation time. Capture ends when the line has stayed in space for a programmable idle time. At that point the space run in progress is flushed as a final byte. A packet-end strobe is raised in the same cycle. The byte stream and the strobe are meant to feed a receive FIFO, and software decodes the remote-control frame from there.

The configuration is one 24-bit word plus a polarity control. Both are expected to be held stable while a packet is being captured.

Top module: `ir_runlen_sampler`

## Requirements
- R1: While `rst_n` is low at a clock edge, `byte_valid` and `pkt_end` are low after that edge. No byte is emitted until a new mark is captured.
- R2: The sample tick occurs once every `DIV_SLOW` base clocks when `cfg_word[0]` is 1, and once every `DIV_FAST` base clocks when it is 0. The defaults are 128 and 64. Run durations are counted in these sample periods.
- R3: Each emitted byte holds the run level in bit 7 (1 = mark, 0 = space) and the run duration in sample periods in bits 6:0. The duration is never zero.
- R4: When `pol_invert` is 1, a low `ir_in` is a mark and a high `ir_in` is a space. When `pol_invert` is 0, a high `ir_in` is a mark.
- R5: A level change that lasts fewer samples than the 6-bit filter threshold `cfg_word[7:2]` produces no byte. It does not split the surrounding run. A threshold of 0 or 1 accepts every change.
- R6: A run longer than 127 samples is emitted as consecutive bytes of the same level. Every byte except the last carries 127. Two successive bytes of the same level within one packet occur only after a byte of length 127.
- R7: Let N be `cfg_word[15:8]`. When (N+1)×128 consecutive space samples have been seen, the block pulses `pkt_end`. In the same cycle it emits a space byte that holds the space samples counted before the terminating sample.
- R8: After a packet end, no byte is emitted until capture restarts on a mark. The first byte of every packet is a mark byte.
- R9: Let T be `cfg_word[22:16]`. Capture starts once a mark has lasted (T+1) samples, or (T+1)×128 samples when `cfg_word[23]` is 1. A shorter mark produces no byte. The first mark byte counts samples from the activating sample on.
- R10: `byte_valid` and `pkt_end` are single-cycle pulses. At most one byte is emitted per sample tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_word | input | 24 | Sample configuration: [0] divider select, [7:2] filter threshold, [15:8] idle threshold, [22:16] activation threshold, [23] activation ×128 scaling; [1] unused |
| pol_invert | input | 1 | Invert the receiver input before sampling |
| ir_in | input | 1 | Raw receiver output, asynchronous |
| byte_valid | output | 1 | One-cycle strobe: `byte_data` holds a run byte |
| byte_data | output | 8 | Run byte: level in bit 7, duration in bits 6:0 |
| pkt_end | output | 1 | One-cycle strobe marking the end of a packet |

## Verification
Several properties are checked on every cycle: the strobes last one cycle, durations are non-zero, each packet starts with a mark, the end byte is a space, and a repeated level within a packet follows a 127 byte. Exact durations, the divider selection, the filter, the polarity inversion, the idle timeout and the activation threshold depend on the waveform history over many samples. Only the bench can show these. It runs a behavioural reference model that predicts every output on every clock, and it adds per-scenario checks on the collected bytes.

// File: rtl/ir_pkg.sv
// Shared types for the infrared run-length sampler.
// Assumes the configuration word is 24 bits wide with the field layout below.
package ir_pkg;

    localparam int RUN_W   = 7;
    localparam int FILT_W  = 6;
    localparam int IDLE_TW = 8;
    localparam int ACT_TW  = 7;
    localparam logic [RUN_W-1:0] RUN_MAX = '1;

    // Configuration word layout, most significant field first.
    typedef struct packed {
        logic               act_scale;  // [23] activation threshold x128
        logic [ACT_TW-1:0]  act_thr;    // [22:16]
        logic [IDLE_TW-1:0] idle_thr;   // [15:8]
        logic [FILT_W-1:0]  filt_thr;   // [7:2]
        logic               rsvd;       // [1]
        logic               slow_div;   // [0]
    } cfg_t;

    typedef struct packed {
        logic             lvl;
        logic [RUN_W-1:0] len;
    } run_byte_t;

    typedef enum logic {
        ENC_WAIT = 1'b0,
        ENC_CAPT = 1'b1
    } enc_state_e;

endpackage

// File: rtl/ir_tick_gen.sv
// Sample tick generator.
// Produces a one-cycle tick every DIV_FAST or DIV_SLOW base clocks, chosen by
// slow_sel. Assumes both divisors are at least 2.
module ir_tick_gen #(
    parameter int DIV_FAST = 64,
    parameter int DIV_SLOW = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slow_sel,
    output logic tick
);
    localparam int DIV_MAX = (DIV_SLOW > DIV_FAST) ? DIV_SLOW : DIV_FAST;
    localparam int CNT_W   = $clog2(DIV_MAX);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_w;

    // Terminal count for the selected divisor.
    assign last_w = slow_sel ? CNT_W'(DIV_SLOW - 1) : CNT_W'(DIV_FAST - 1);
    assign tick   = (cnt_q >= last_w);

    // Free-running divider counter, restarted on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/ir_glitch_filter.sv
// Level filter on the sample tick.
// A new level is accepted once it has been seen on thr consecutive samples
// (one sample when thr is 0). Every edge is delayed equally, so run lengths
// are preserved. Assumes raw is already synchronised to clk.
module ir_glitch_filter #(
    parameter int FILT_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              raw,
    input  logic [FILT_W-1:0] thr,
    output logic              level
);
    logic [FILT_W-1:0] pend_q;
    logic [FILT_W:0]   need_w;
    logic [FILT_W:0]   seen_w;

    // Samples needed to accept a change, and samples seen including this one.
    assign need_w = (thr == '0) ? (FILT_W+1)'(1) : {1'b0, thr};
    assign seen_w = {1'b0, pend_q} + 1'b1;

    // Track how long the input has disagreed with the accepted level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level  <= 1'b0;
            pend_q <= '0;
        end else if (tick) begin
            if (raw != level) begin
                if (seen_w >= need_w) begin
                    level  <= raw;
                    pend_q <= '0;
                end else begin
                    pend_q <= seen_w[FILT_W-1:0];
                end
            end else begin
                pend_q <= '0;
            end
        end
    end
endmodule

// File: rtl/ir_run_encoder.sv
// Run-length encoder with packet framing.
// Waits for a mark of the activation length, then emits one byte per run of
// equal level, splitting runs at 127 samples. It closes the packet after the
// idle length of space. Assumes tick is never high on two consecutive cycles.
module ir_run_encoder
    import ir_pkg::*;
#(
    parameter int IDLE_UNIT = 128,
    parameter int ACT_UNIT  = 128
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               level,
    input  logic [IDLE_TW-1:0] idle_thr,
    input  logic [ACT_TW-1:0]  act_thr,
    input  logic               act_scale,
    output logic               byte_valid,
    output logic [7:0]         byte_data,
    output logic               pkt_end
);
    localparam int IDLE_W = $clog2((1 << IDLE_TW) * IDLE_UNIT + 1);
    localparam int ARM_W  = $clog2((1 << ACT_TW) * ACT_UNIT + 1);

    enc_state_e       state_q;
    logic             cur_q;
    logic [RUN_W-1:0] run_q;
    logic [IDLE_W-1:0] idle_q;
    logic [ARM_W-1:0]  arm_q;

    logic [IDLE_W-1:0] idle_len_w;
    logic [ARM_W-1:0]  act_len_w;
    logic [IDLE_W-1:0] idle_inc_w;
    logic [ARM_W-1:0]  arm_inc_w;
    logic              idle_hit_w;
    run_byte_t         out_w;

    // Threshold lengths in samples, derived from the configuration fields.
    always_comb begin
        idle_len_w = (IDLE_W'(idle_thr) + 1'b1) * IDLE_W'(IDLE_UNIT);
        act_len_w  = (ARM_W'(act_thr) + 1'b1) *
                     (act_scale ? ARM_W'(ACT_UNIT) : ARM_W'(1));
        idle_inc_w = idle_q + 1'b1;
        arm_inc_w  = arm_q + 1'b1;
        idle_hit_w = !level && !cur_q && (idle_inc_w >= idle_len_w);
    end

    // Byte carrying the run in progress.
    assign out_w.lvl = cur_q;
    assign out_w.len = run_q;

    // Packet framing and run counting, evaluated on each sample tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ENC_WAIT;
            cur_q      <= 1'b0;
            run_q      <= '0;
            idle_q     <= '0;
            arm_q      <= '0;
            byte_valid <= 1'b0;
            byte_data  <= '0;
            pkt_end    <= 1'b0;
        end else begin
            byte_valid <= 1'b0;
            pkt_end    <= 1'b0;
            if (tick) begin
                case (state_q)
                    ENC_WAIT: begin
                        if (level) begin
                            if (arm_inc_w >= act_len_w) begin
                                state_q <= ENC_CAPT;
                                cur_q   <= 1'b1;
                                run_q   <= RUN_W'(1);
                                idle_q  <= '0;
                                arm_q   <= '0;
                            end else begin
                                arm_q <= arm_inc_w;
                            end
                        end else begin
                            arm_q <= '0;
                        end
                    end
                    ENC_CAPT: begin
                        if (idle_hit_w) begin
                            byte_valid <= 1'b1;
                            byte_data  <= out_w;
                            pkt_end    <= 1'b1;
                            state_q    <= ENC_WAIT;
                            arm_q      <= '0;
                            idle_q     <= '0;
                        end else if (level == cur_q) begin
                            if (run_q == RUN_MAX) begin
                                byte_valid <= 1'b1;
                                byte_data  <= out_w;
                                run_q      <= RUN_W'(1);
                            end else begin
                                run_q <= run_q + 1'b1;
                            end
                            if (!level) begin
                                idle_q <= idle_inc_w;
                            end
                        end else begin
                            byte_valid <= 1'b1;
                            byte_data  <= out_w;
                            cur_q      <= level;
                            run_q      <= RUN_W'(1);
                            idle_q     <= level ? '0 : IDLE_W'(1);
                        end
                    end
                    default: state_q <= ENC_WAIT;
                endcase
            end
        end
    end
endmodule

// File: rtl/ir_runlen_sampler.sv
// Top of the infrared run-length sampler.
// Synchronises and optionally inverts the receiver input, samples it on a
// divided tick, filters short level changes and encodes runs into bytes.
// Assumes cfg_word and pol_invert are held stable during a packet.
module ir_runlen_sampler
    import ir_pkg::*;
#(
    parameter int DIV_FAST    = 64,
    parameter int DIV_SLOW    = 128,
    parameter int IDLE_UNIT   = 128,
    parameter int ACT_UNIT    = 128,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [23:0] cfg_word,
    input  logic        pol_invert,
    input  logic        ir_in,
    output logic        byte_valid,
    output logic [7:0]  byte_data,
    output logic        pkt_end
);
    cfg_t cfg;
    logic cfg_unused;
    logic [SYNC_STAGES-1:0] sync_q;
    logic raw_w;
    logic tick_w;
    logic level_w;

    assign cfg        = cfg_t'(cfg_word);
    assign cfg_unused = cfg.rsvd;

    // Input synchroniser chain; polarity is applied at its entry.
    genvar gi;
    generate
        for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
            if (gi == 0) begin : g_first
                // First stage captures the possibly inverted pin.
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[0] <= 1'b0;
                    else        sync_q[0] <= ir_in ^ pol_invert;
                end
            end else begin : g_next
                // Further stages shift the level along.
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[gi] <= 1'b0;
                    else        sync_q[gi] <= sync_q[gi-1];
                end
            end
        end
    endgenerate

    assign raw_w = sync_q[SYNC_STAGES-1];

    ir_tick_gen #(
        .DIV_FAST (DIV_FAST),
        .DIV_SLOW (DIV_SLOW)
    ) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .slow_sel (cfg.slow_div),
        .tick     (tick_w)
    );

    ir_glitch_filter #(
        .FILT_W (FILT_W)
    ) u_filt (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick_w),
        .raw   (raw_w),
        .thr   (cfg.filt_thr),
        .level (level_w)
    );

    ir_run_encoder #(
        .IDLE_UNIT (IDLE_UNIT),
        .ACT_UNIT  (ACT_UNIT)
    ) u_enc (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick_w),
        .level      (level_w),
        .idle_thr   (cfg.idle_thr),
        .act_thr    (cfg.act_thr),
        .act_scale  (cfg.act_scale),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .pkt_end    (pkt_end)
    );
endmodule

// File: rtl/ir_runlen_sampler_chk.sv
// Property checker for the run-length sampler, observing its output ports.
// Assumes both divisors are at least 2, so bytes never come back to back.
module ir_runlen_sampler_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       byte_valid,
    input logic [7:0] byte_data,
    input logic       pkt_end
);
    logic       have_last_q;
    logic       last_lvl_q;
    logic [6:0] last_len_q;

    // Remember the previous byte of the current packet.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have_last_q <= 1'b0;
            last_lvl_q  <= 1'b0;
            last_len_q  <= '0;
        end else if (pkt_end) begin
            have_last_q <= 1'b0;
        end else if (byte_valid) begin
            have_last_q <= 1'b1;
            last_lvl_q  <= byte_data[7];
            last_len_q  <= byte_data[6:0];
        end
    end

    // R1: reset silences both strobes.
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!byte_valid && !pkt_end));

    // R3: durations are never zero.
    a_r3_len_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |-> (byte_data[6:0] != 7'd0));

    // R6: a repeated level inside a packet follows a full byte.
    a_r6_split_full: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && have_last_q && (byte_data[7] == last_lvl_q))
            |-> (last_len_q == 7'd127));

    // R7: the packet end comes with a space byte.
    a_r7_end_space: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_end |-> (byte_valid && !byte_data[7]));

    // R8: the first byte of a packet is a mark.
    a_r8_first_mark: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && !have_last_q) |-> byte_data[7]);

    // R10: strobes last a single cycle.
    a_r10_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |=> !byte_valid);

    a_r10_end_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_end |=> !pkt_end);
endmodule

bind ir_runlen_sampler ir_runlen_sampler_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .byte_valid (byte_valid),
    .byte_data  (byte_data),
    .pkt_end    (pkt_end)
);

// File: tb/ir_runlen_sampler_tb.sv
// Bench: behavioural reference model compared on every clock, plus
// per-scenario checks on the collected bytes.
module ir_runlen_sampler_tb;
    localparam int FAST = 4;
    localparam int SLOW = 8;
    localparam int UNIT = 128;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] cfg_word = '0;
    logic        pol_invert = 1'b0;
    logic        ir_in = 1'b0;
    logic        byte_valid;
    logic [7:0]  byte_data;
    logic        pkt_end;

    int checks = 0;
    int errors = 0;
    int cur_div = FAST;
    string tag = "R1";

    ir_runlen_sampler #(
        .DIV_FAST (FAST),
        .DIV_SLOW (SLOW)
    ) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_word   (cfg_word),
        .pol_invert (pol_invert),
        .ir_in      (ir_in),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .pkt_end    (pkt_end)
    );

    always #2.5 clk = ~clk;

    // ---------------- reference model ----------------
    int m_cnt, m_s0, m_s1, m_lvl, m_pend, m_act, m_cur, m_run, m_idle, m_arm;
    int exp_v, exp_d, exp_p;

    always @(posedge clk) begin
        int div, thr, need, idle_len, act_len;
        bit tk;
        if (!rst_n) begin
            m_cnt = 0; m_s0 = 0; m_s1 = 0; m_lvl = 0; m_pend = 0;
            m_act = 0; m_cur = 0; m_run = 0; m_idle = 0; m_arm = 0;
            exp_v = 0; exp_d = 0; exp_p = 0;
        end else begin
            div = cfg_word[0] ? SLOW : FAST;
            tk = (m_cnt >= div - 1);
            exp_v = 0; exp_p = 0;
            if (tk) begin
                idle_len = (int'(cfg_word[15:8]) + 1) * UNIT;
                act_len  = (int'(cfg_word[22:16]) + 1) * (cfg_word[23] ? UNIT : 1);
                if (!m_act) begin
                    if (m_lvl == 1) begin
                        if (m_arm + 1 >= act_len) begin
                            m_act = 1; m_cur = 1; m_run = 1; m_idle = 0; m_arm = 0;
                        end else m_arm++;
                    end else m_arm = 0;
                end else if (m_lvl == 0 && m_cur == 0 && m_idle + 1 >= idle_len) begin
                    exp_v = 1; exp_p = 1; exp_d = m_run;
                    m_act = 0; m_arm = 0; m_idle = 0;
                end else if (m_lvl == m_cur) begin
                    if (m_run == 127) begin
                        exp_v = 1; exp_d = (m_cur << 7) | 127; m_run = 1;
                    end else m_run++;
                    if (m_lvl == 0) m_idle++;
                end else begin
                    exp_v = 1; exp_d = (m_cur << 7) | m_run;
                    m_cur = m_lvl; m_run = 1; m_idle = (m_lvl == 1) ? 0 : 1;
                end
                thr = int'(cfg_word[7:2]);
                need = (thr == 0) ? 1 : thr;
                if (m_s1 != m_lvl) begin
                    if (m_pend + 1 >= need) begin
                        m_lvl = m_s1; m_pend = 0;
                    end else m_pend++;
                end else m_pend = 0;
            end
            m_cnt = tk ? 0 : m_cnt + 1;
            m_s1 = m_s0;
            m_s0 = int'(ir_in ^ pol_invert);
        end
    end

    // ---------------- comparison and collection ----------------
    logic [7:0] got[$];
    int n_end = 0;
    int b2b = 0;
    logic prev_v = 1'b0;

    always @(negedge clk) begin
        checks++;
        if (byte_valid !== exp_v[0] || pkt_end !== exp_p[0] ||
            (exp_v != 0 && byte_data !== exp_d[7:0])) begin
            errors++;
            $display("FAIL %s model: got v=%0b d=%02h e=%0b exp v=%0d d=%02h e=%0d",
                     tag, byte_valid, byte_data, pkt_end, exp_v, exp_d, exp_p);
        end
        if (byte_valid === 1'b1) got.push_back(byte_data);
        if (pkt_end === 1'b1) n_end++;
        if (byte_valid === 1'b1 && prev_v) b2b++;
        prev_v = (byte_valid === 1'b1);
    end

    task automatic chk(input string req, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic chk_rng(input string req, input int act, input int lo, input int hi);
        checks++;
        if (act < lo || act > hi) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic hold(input logic lvl, input int samples);
        ir_in = lvl;
        repeat (samples * cur_div) @(negedge clk);
    endtask

    function automatic logic [23:0] mk_cfg(input bit slow, input int filt,
                                          input int idle, input int act, input bit sc);
        return {sc, 7'(act), 8'(idle), 6'(filt), 1'b0, slow};
    endfunction

    task automatic start(input string t);
        tag = t;
        got.delete();
        n_end = 0;
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // ---------------- scenarios ----------------
    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        chk("R1 valid in reset", int'(byte_valid), 0);
        chk("R1 pkt_end in reset", int'(pkt_end), 0);
        rst_n = 1'b1;
        cfg_word = mk_cfg(0, 0, 0, 0, 0);
        cur_div = FAST;
        repeat (20) @(negedge clk);
        chk("R1 no byte before mark", got.size(), 0);

        // R3 / R7: basic packet
        start("R3");
        hold(1, 9); hold(0, 5); hold(1, 9); hold(0, 14); hold(1, 9); hold(0, 140);
        chk("R3 byte count", got.size(), 6);
        chk("R3 first level", int'(got[0][7]), 1);
        chk_rng("R3 first length", int'(got[0][6:0]), 8, 10);
        chk("R3 second level", int'(got[1][7]), 0);
        chk("R7 end count", n_end, 1);
        chk("R7 final byte", int'(got[got.size()-1]), 8'h7F);

        // R2: slow divider
        start("R2");
        cfg_word = mk_cfg(1, 0, 0, 0, 0);
        cur_div = SLOW;
        hold(1, 20); hold(0, 140);
        chk("R2 byte count", got.size(), 2);
        chk_rng("R2 slow length", int'(got[0][6:0]), 19, 21);

        // R4: inverted polarity
        start("R4");
        cfg_word = mk_cfg(0, 0, 0, 0, 0);
        cur_div = FAST;
        ir_in = 1'b1; pol_invert = 1'b1;
        repeat (8) @(negedge clk);
        hold(0, 12); hold(1, 140);
        chk("R4 byte count", got.size(), 2);
        chk("R4 low is mark", int'(got[0][7]), 1);
        chk_rng("R4 mark length", int'(got[0][6:0]), 11, 13);
        ir_in = 1'b0; pol_invert = 1'b0;
        repeat (8) @(negedge clk);

        // R5: glitch filter
        start("R5");
        cfg_word = mk_cfg(0, 3, 0, 0, 0);
        hold(1, 20); hold(0, 2); hold(1, 20); hold(0, 140);
        chk("R5 glitch ignored count", got.size(), 2);
        chk_rng("R5 merged length", int'(got[0][6:0]), 41, 43);

        // R6: long run split
        start("R6");
        cfg_word = mk_cfg(0, 0, 0, 0, 0);
        hold(1, 300); hold(0, 140);
        chk("R6 byte count", got.size(), 4);
        chk("R6 first full", int'(got[0]), 8'hFF);
        chk("R6 second full", int'(got[1]), 8'hFF);
        chk_rng("R6 remainder", int'(got[2]), 8'h80 + 44, 8'h80 + 47);

        // R7 / R8: idle threshold N=1 and quiet after end
        start("R7");
        cfg_word = mk_cfg(0, 0, 1, 0, 0);
        hold(1, 5); hold(0, 200);
        chk("R7 no early end", n_end, 0);
        hold(0, 80);
        chk("R7 end after 256", n_end, 1);
        chk("R7 end byte is space", int'(got[got.size()-1][7]), 0);
        start("R8");
        hold(0, 300);
        chk("R8 silent after end", got.size(), 0);

        // R9: activation threshold T=3
        start("R9");
        cfg_word = mk_cfg(0, 0, 0, 3, 0);
        hold(1, 2); hold(0, 10);
        chk("R9 short mark ignored", got.size(), 0);
        hold(1, 10); hold(0, 140);
        chk("R9 byte count", got.size(), 2);
        chk_rng("R9 length from activation", int'(got[0][6:0]), 6, 8);

        // R10: no back-to-back strobes seen anywhere
        chk("R10 back-to-back bytes", b2b, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule